// File: doc/BRIEF.md
# Pipeline Data-Hazard Stall and Forward Control

This block guards a five-stage in-order pipeline (fetch, register read, execute, memory, write-back) against read-after-write hazards. Each cycle it takes the instruction sitting in register read, meaning its source indices, its read enables and its own write enable and destination. It compares every enabled source against the destinations of the three older instructions still in flight. The block keeps those three older write enables and destinations itself, in a short delay line that advances one stage per cycle.

A match with the instruction one cycle older (age 1) cannot be served, so it raises `stall`. While `stall` is high the surrounding datapath holds the PC and the fetch/register-read register, and the block turns the instruction entering execute into a bubble. Matches with age 2 or age 3 are served by forwarding when no younger match exists. The select code is registered at the register-read/execute boundary and drives a per-operand multiplexer in front of the ALU. The block has no data stream of its own: back-pressure to the front end is the `stall` pin. `bubble` tells the register-read/execute register to discard its payload.

Top module: `hzd_fwd_unit`

## Requirements
- R1: After synchronous active-high reset, all delayed write enables are 0, `wb_we` is 0, every forward select is 00 and `stall` is 0 while no age holds a write.
- R2: For each operand, an enabled source equal to the age-1 destination with the age-1 write enable high makes `stall` 1. `bubble` equals `stall` in every cycle.
- R3: An operand whose source matches age 2 but not age 1 does not stall. In the next cycle its select is 01, the age-2 code.
- R4: An operand whose source matches age 3 but neither age 1 nor age 2 does not stall. In the next cycle its select is 10, the age-3 code.
- R5: When both age 2 and age 3 match an operand, the select is 01. The value 11 never appears.
- R6: Source index 0 never produces a stall or a forward select.
- R7: An operand with its read enable low produces no stall and select 00, whatever its index.
- R8: `rr_we`/`rr_dst` reach `wb_we`/`wb_dst` three cycles later. An instruction accepted while `stall` is high enters with its write enable cleared.
- R9: In the cycle after `stall` is high, every forward select is 00.
- R10: ALU operand i, bits [i*XLEN +: XLEN], equals `ex_rf_opnd` for select 00, the current `wb_data` for 01, and the `wb_data` of the previous cycle for 10.
- R11: `stall` is the OR of the per-operand stall terms. A hazard on operand 1 (bits [2*AW-1:AW]) alone is enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_re | input | NUM_SRC | Read enable per source operand of the register-read instruction |
| rr_src | input | NUM_SRC*AW | Source indices, operand i at [i*AW +: AW] |
| rr_we | input | 1 | Write enable of the register-read instruction |
| rr_dst | input | AW | Destination index of the register-read instruction |
| ex_rf_opnd | input | NUM_SRC*XLEN | Register-file operands now in execute |
| wb_data | input | XLEN | Result of the instruction in write-back |
| stall | output | 1 | Hold PC and fetch/register-read register |
| bubble | output | 1 | Clear the instruction entering execute |
| fwd_sel | output | NUM_SRC*2 | Registered forward select per operand (00 RF, 01 age 2, 10 age 3) |
| alu_opnd | output | NUM_SRC*XLEN | Forwarded ALU operands |
| wb_we | output | 1 | Delayed write enable at write-back |
| wb_dst | output | AW | Delayed destination at write-back |

## Verification
The assertions assume that all inputs carry known values from the first clock after reset. They also assume that `wb_data` carries the result of the instruction whose write enable the block is presenting on `wb_we`. The bench drives every input to a defined value at each falling edge, beginning during reset. It draws indices from a small range, so that age matches are frequent. Directed sequences first repeat a stalled instruction unchanged, as the real front end would, and then move on.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF   = 2'b00,
    FWD_AGE2 = 2'b01,
    FWD_AGE3 = 2'b10
  } fwd_sel_t;
endpackage

// File: rtl/hzd_age_pipe.sv
module hzd_age_pipe #(
  parameter int AW    = 5,
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_we,
  input  logic [AW-1:0]            in_dst,
  input  logic                     kill,
  output logic [DEPTH-1:0]         age_we,
  output logic [DEPTH-1:0][AW-1:0] age_dst
);
  // Stage 0 is the instruction in execute (age 1); stage DEPTH-1 is write-back.
  always_ff @(posedge clk) begin
    if (rst) begin
      age_we  <= '0;
      age_dst <= '0;
    end else begin
      age_we[0]  <= in_we & ~kill;
      age_dst[0] <= in_dst;
      for (int k = 1; k < DEPTH; k++) begin
        age_we[k]  <= age_we[k-1];
        age_dst[k] <= age_dst[k-1];
      end
    end
  end

  assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
    kill |=> !age_we[0]);

  assert_shift_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (age_we[DEPTH-1] == $past(age_we[DEPTH-2])));
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                 re,
  input  logic [AW-1:0]        src,
  input  logic [2:0]           age_we,
  input  logic [2:0][AW-1:0]   age_dst,
  output logic                 need_stall,
  output fwd_sel_t             sel
);
  logic [2:0] hit;
  logic       raw, f_near, f_far;

  always_comb begin
    for (int k = 0; k < 3; k++)
      hit[k] = re && (src != '0) && age_we[k] && (age_dst[k] == src);
    raw        = |hit;
    f_near     = hit[1] & ~hit[0];
    f_far      = hit[2] & ~hit[0] & ~hit[1];
    need_stall = raw & ~f_near & ~f_far;
    if (f_near)     sel = FWD_AGE2;
    else if (f_far) sel = FWD_AGE3;
    else            sel = FWD_RF;
  end
endmodule

// File: rtl/hzd_fwd_mux.sv
module hzd_fwd_mux
  import hzd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  fwd_sel_t          sel,
  input  logic [XLEN-1:0]   rf_val,
  input  logic [XLEN-1:0]   near_val,
  input  logic [XLEN-1:0]   far_val,
  output logic [XLEN-1:0]   out_val
);
  always_comb begin
    case (sel)
      FWD_AGE2: out_val = near_val;
      FWD_AGE3: out_val = far_val;
      default:  out_val = rf_val;
    endcase
  end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int XLEN    = 32,
  parameter int NUM_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_SRC-1:0]      rr_re,
  input  logic [NUM_SRC*AW-1:0]   rr_src,
  input  logic                    rr_we,
  input  logic [AW-1:0]           rr_dst,
  input  logic [NUM_SRC*XLEN-1:0] ex_rf_opnd,
  input  logic [XLEN-1:0]         wb_data,
  output logic                    stall,
  output logic                    bubble,
  output logic [NUM_SRC*2-1:0]    fwd_sel,
  output logic [NUM_SRC*XLEN-1:0] alu_opnd,
  output logic                    wb_we,
  output logic [AW-1:0]           wb_dst
);
  localparam int AGES = 3;

  logic [AGES-1:0]         age_we;
  logic [AGES-1:0][AW-1:0] age_dst;
  logic [NUM_SRC-1:0]      op_stall;
  logic [XLEN-1:0]         wb_data_q;

  hzd_age_pipe #(.AW(AW), .DEPTH(AGES)) u_age (
    .clk(clk), .rst(rst), .in_we(rr_we), .in_dst(rr_dst), .kill(stall),
    .age_we(age_we), .age_dst(age_dst)
  );

  always_ff @(posedge clk) begin
    if (rst) wb_data_q <= '0;
    else     wb_data_q <= wb_data;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
    fwd_sel_t        sel_d, sel_q;
    logic [AW-1:0]   src;
    assign src = rr_src[i*AW +: AW];

    hzd_detect #(.AW(AW)) u_det (
      .re(rr_re[i]), .src(src), .age_we(age_we), .age_dst(age_dst),
      .need_stall(op_stall[i]), .sel(sel_d)
    );

    always_ff @(posedge clk) begin
      if (rst)        sel_q <= FWD_RF;
      else if (stall) sel_q <= FWD_RF;
      else            sel_q <= sel_d;
    end

    assign fwd_sel[i*2 +: 2] = sel_q;

    hzd_fwd_mux #(.XLEN(XLEN)) u_mux (
      .sel(sel_q), .rf_val(ex_rf_opnd[i*XLEN +: XLEN]),
      .near_val(wb_data), .far_val(wb_data_q),
      .out_val(alu_opnd[i*XLEN +: XLEN])
    );

    assert_age1_stall_R2: assert property (@(posedge clk) disable iff (rst)
      (rr_re[i] && src != '0 && age_we[0] && age_dst[0] == src) |-> stall);

    assert_zero_src_R6: assert property (@(posedge clk) disable iff (rst)
      (src == '0) |-> (!op_stall[i] && sel_d == FWD_RF));

    assert_no_read_R7: assert property (@(posedge clk) disable iff (rst)
      !rr_re[i] |-> (!op_stall[i] && sel_d == FWD_RF));

    assert_sel_after_stall_R9: assert property (@(posedge clk) disable iff (rst)
      stall |=> (fwd_sel[i*2 +: 2] == 2'b00));

    assert_sel_legal_R5: assert property (@(posedge clk) disable iff (rst)
      fwd_sel[i*2 +: 2] != 2'b11);

    assert_far_fwd_R10: assert property (@(posedge clk) disable iff (rst)
      (fwd_sel[i*2 +: 2] == 2'b10 && !$past(rst)) |->
        (alu_opnd[i*XLEN +: XLEN] == $past(wb_data)));
  end

  assign stall  = |op_stall;
  assign bubble = stall;
  assign wb_we  = age_we[AGES-1];
  assign wb_dst = age_dst[AGES-1];

  assert_or_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (|op_stall) |-> (stall && bubble));
endmodule

// File: tb/hzd_fwd_unit_tb.sv
module hzd_fwd_unit_tb;
  localparam int AW = 5, XLEN = 32, NS = 2;

  logic              clk = 1'b0, rst = 1'b1;
  logic [NS-1:0]     rr_re = '0;
  logic [NS*AW-1:0]  rr_src = '0;
  logic              rr_we = 1'b0;
  logic [AW-1:0]     rr_dst = '0;
  logic [NS*XLEN-1:0] ex_rf_opnd = '0;
  logic [XLEN-1:0]   wb_data = '0;
  logic              stall, bubble, wb_we;
  logic [NS*2-1:0]   fwd_sel;
  logic [NS*XLEN-1:0] alu_opnd;
  logic [AW-1:0]     wb_dst;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // Reference state
  logic [2:0]        m_we;
  logic [AW-1:0]     m_dst [3];
  logic [1:0]        m_sel [NS];
  logic [XLEN-1:0]   m_wbq;

  hzd_fwd_unit #(.AW(AW), .XLEN(XLEN), .NUM_SRC(NS)) u_dut (
    .clk(clk), .rst(rst), .rr_re(rr_re), .rr_src(rr_src), .rr_we(rr_we),
    .rr_dst(rr_dst), .ex_rf_opnd(ex_rf_opnd), .wb_data(wb_data),
    .stall(stall), .bubble(bubble), .fwd_sel(fwd_sel), .alu_opnd(alu_opnd),
    .wb_we(wb_we), .wb_dst(wb_dst)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_we = '0; m_wbq = '0;
    for (int k = 0; k < 3; k++) m_dst[k] = '0;
    for (int i = 0; i < NS; i++) m_sel[i] = 2'b00;
  endtask

  task automatic step(input logic [NS-1:0] re, input logic [NS*AW-1:0] src,
                      input logic we, input logic [AW-1:0] dst,
                      input logic [NS*XLEN-1:0] rf, input logic [XLEN-1:0] wbd,
                      input string tag);
    logic          st_e;
    logic [1:0]    sel_e [NS];
    logic [XLEN-1:0] op_e;
    @(negedge clk);
    rr_re = re; rr_src = src; rr_we = we; rr_dst = dst; ex_rf_opnd = rf; wb_data = wbd;
    #1;
    st_e = 1'b0;
    for (int i = 0; i < NS; i++) begin
      logic [AW-1:0] s;
      logic h1, h2, h3, f1, f2;
      s  = src[i*AW +: AW];
      h1 = re[i] && s != 0 && m_we[0] && m_dst[0] == s;
      h2 = re[i] && s != 0 && m_we[1] && m_dst[1] == s;
      h3 = re[i] && s != 0 && m_we[2] && m_dst[2] == s;
      f1 = h2 && !h1;
      f2 = h3 && !h1 && !h2;
      st_e = st_e | ((h1 | h2 | h3) & !f1 & !f2);
      sel_e[i] = f1 ? 2'b01 : (f2 ? 2'b10 : 2'b00);
    end
    check({tag, " stall"}, stall, st_e);
    check("R2 bubble", bubble, st_e);
    for (int i = 0; i < NS; i++) begin
      check({tag, " sel"}, fwd_sel[i*2 +: 2], m_sel[i]);
      op_e = (m_sel[i] == 2'b01) ? wbd : (m_sel[i] == 2'b10) ? m_wbq : rf[i*XLEN +: XLEN];
      check("R10 alu operand", alu_opnd[i*XLEN +: XLEN], op_e);
    end
    check("R8 wb_we", wb_we, m_we[2]);
    if (m_we[2]) check("R8 wb_dst", wb_dst, m_dst[2]);
    // predict next edge
    for (int i = 0; i < NS; i++) m_sel[i] = st_e ? 2'b00 : sel_e[i];
    m_wbq = wbd;
    m_we = {m_we[1:0], we & !st_e};
    m_dst[2] = m_dst[1]; m_dst[1] = m_dst[0]; m_dst[0] = dst;
  endtask

  function automatic logic [NS*AW-1:0] srcs(input logic [AW-1:0] s1, input logic [AW-1:0] s0);
    return {s1, s0};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state visible at ports
    check("R1 wb_we", wb_we, 1'b0);
    check("R1 fwd_sel", fwd_sel, '0);
    step(2'b00, srcs(0, 0), 1'b1, 5'd5, 64'h1111_0000_2222_0000, 32'hA0, "R1");

    // R2 then R3: consumer held while stalled, then forwarded from age 2
    step(2'b01, srcs(0, 5), 1'b1, 5'd7, 64'h1, 32'hA1, "R2");
    step(2'b01, srcs(0, 5), 1'b1, 5'd7, 64'h2, 32'hA2, "R9");
    step(2'b01, srcs(0, 5), 1'b1, 5'd7, 64'h3, 32'hA3, "R3");
    step(2'b00, srcs(0, 0), 1'b0, 5'd0, 64'h4, 32'hA4, "R10");

    // R4: age-3 forward
    step(2'b00, srcs(0, 0), 1'b1, 5'd9, 64'h5, 32'hB0, "R4");
    step(2'b00, srcs(0, 0), 1'b1, 5'd12, 64'h6, 32'hB1, "R4");
    step(2'b00, srcs(0, 0), 1'b1, 5'd13, 64'h7, 32'hB2, "R4");
    step(2'b10, srcs(9, 0), 1'b0, 5'd0, 64'h8, 32'hB3, "R4");
    step(2'b00, srcs(0, 0), 1'b0, 5'd0, 64'h9, 32'hB4, "R4");

    // R5: both age 2 and age 3 match
    step(2'b00, srcs(0, 0), 1'b1, 5'd3, 64'h0, 32'hC0, "R5");
    step(2'b00, srcs(0, 0), 1'b1, 5'd3, 64'h0, 32'hC1, "R5");
    step(2'b00, srcs(0, 0), 1'b1, 5'd20, 64'h0, 32'hC2, "R5");
    step(2'b01, srcs(0, 3), 1'b0, 5'd0, 64'h0, 32'hC3, "R5");
    step(2'b00, srcs(0, 0), 1'b0, 5'd0, 64'h0, 32'hC4, "R5");

    // R6: index zero
    step(2'b00, srcs(0, 0), 1'b1, 5'd0, 64'h0, 32'hD0, "R6");
    step(2'b11, srcs(0, 0), 1'b0, 5'd0, 64'h0, 32'hD1, "R6");
    check("R6 no stall", stall, 1'b0);

    // R7: read enable low
    step(2'b00, srcs(0, 0), 1'b1, 5'd6, 64'h0, 32'hD2, "R7");
    step(2'b00, srcs(6, 6), 1'b0, 5'd0, 64'h0, 32'hD3, "R7");
    check("R7 no stall", stall, 1'b0);

    // R11: operand 1 alone stalls
    step(2'b00, srcs(0, 0), 1'b1, 5'd11, 64'h0, 32'hE0, "R11");
    step(2'b10, srcs(11, 4), 1'b1, 5'd14, 64'h0, 32'hE1, "R11");
    check("R11 stall", stall, 1'b1);
    step(2'b10, srcs(11, 4), 1'b1, 5'd14, 64'h0, 32'hE2, "R9");
    step(2'b10, srcs(11, 4), 1'b1, 5'd14, 64'h0, 32'hE3, "R3");

    // Random phase: indices from a small range to provoke matches
    for (int n = 0; n < 4000; n++) begin
      logic [NS*AW-1:0] s;
      s = srcs(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)));
      step(NS'($urandom_range(0, 3)), s, 1'($urandom_range(0, 1)),
           AW'($urandom_range(0, 3)), {$urandom, $urandom}, $urandom, "R11");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule